// File: doc/BRIEF.md
# Serial Keyboard Host Receiver

This block is the host end of a two-wire keyboard link in which both the clock and the data line are open-drain. The keyboard clocks out one scancode frame. The receiver samples the data line on every rising edge of the keyboard clock and shifts the bit into a frame register. A frame is nine bits: a start bit that is always 1, then the eight code bits, lowest bit first. When the start bit reaches the last stage of the register, the frame is complete. The block then raises a sticky interrupt and pulls the data line low, so the keyboard cannot send another byte until software releases the link.

Software controls the block through an 8-bit control write port, of which only two bit positions have meaning. Bit 6 decides who owns the clock line. When it is 0 the host holds the clock low. When it is 1 the keyboard may drive the clock. Bit 7 is a clear. While it is 1, the frame register stays empty, the read port returns zero, and the interrupt and the data clamp are released. After reading each scancode, software writes bit 7 to 1 and then back to 0.

The keyboard side enters as two release levels (1 = keyboard lets the line float high). The host side leaves as two pull-low enables. Inside the block, each line level is the AND of both sides. The keyboard clock is synchronised through a configurable flop chain, and rising edges are detected on the synchronised signal.

Top module: `kbd_host_rx`

## Requirements
- R1: A frame completes only when the start bit, always 1, has been shifted into the final (ninth) stage. From an empty register this needs exactly 9 rising edges of the clock line. After 8 edges the interrupt is still 0.
- R2: Code bits arrive lowest bit first. The read port shows the bit sampled at the second edge as bit 0, and the bit sampled at the ninth edge as bit 7.
- R3: The data line is sampled only on rising edges of the resolved clock line. Low phases and falling edges shift nothing.
- R4: After a frame completes, `irq` and `kbd_dat_drive_low` both go to 1 within a few system cycles.
- R5: Once a frame is held, `irq` and `kbd_dat_drive_low` stay at 1, and further clock edges leave the read value unchanged, until a clear is written.
- R6: Writing control bit 7 = 1 empties the frame register and drops `irq` and `kbd_dat_drive_low`. After bit 7 returns to 0, no frame completes before 9 new rising edges.
- R7: While control bit 7 is 1, `rd_data` reads 0x00, and no frame can complete whatever the keyboard sends.
- R8: While control bit 6 is 0, `kbd_clk_drive_low` is 1 and keyboard clock pulses have no effect. With bit 6 = 1, the host releases the clock line.
- R9: After reset, both control bits are 0. This means the clock is held low, `irq` = 0, `rd_data` = 0x00 and the data line is released.
- R10: Each line is modelled open-drain: it reads low when either side pulls it low, and high otherwise. A keyboard data level of 0 therefore shifts in a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_rel | input | 1 | Keyboard clock release (0 = keyboard pulls clock low) |
| kbd_dat_rel | input | 1 | Keyboard data release (0 = keyboard pulls data low) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data; bit 7 = clear, bit 6 = clock enable |
| kbd_clk_drive_low | output | 1 | Host pulls the clock line low |
| kbd_dat_drive_low | output | 1 | Host pulls the data line low (frame held) |
| irq | output | 1 | Sticky frame-complete interrupt |
| rd_data | output | CODE_W (8) | Received scancode, 0x00 while clear is set |

## Verification
A software clear and a frame completion can land in the same cycle. That cycle is where the final shift sets the frame-held flag and the clear write resets it. To provoke the collision, the bench raises the ninth keyboard clock edge and then writes the clear at each offset from 0 to 6 system cycles later. The result is correct only if the clear wins in every case: after the write, `irq` and the data clamp are 0 and the read port shows zero. A fresh frame sent afterwards must then be received intact.

// File: rtl/kbd_rx_pkg.sv
`timescale 1ns/1ps
package kbd_rx_pkg;
  // Control-word bit positions seen by software
  localparam int unsigned CTL_CLR_BIT   = 7;
  localparam int unsigned CTL_CLKEN_BIT = 6;
  localparam int unsigned CTL_W         = 8;

  typedef struct packed {
    logic clr;     // empty receiver, hide data, release irq/clamp
    logic clk_en;  // 1: keyboard owns the clock line
  } kbd_ctl_t;
endpackage

// File: rtl/kbd_rx_edge.sv
`timescale 1ns/1ps
module kbd_rx_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic dat_line,
  output logic rise,
  output logic dat_s
);
  logic [STAGES-1:0] clk_sync_q, clk_sync_d;
  logic [STAGES-1:0] dat_sync_q, dat_sync_d;
  logic              clk_prev_q;

  always_comb begin
    clk_sync_d = {clk_sync_q[STAGES-2:0], clk_line};
    dat_sync_d = {dat_sync_q[STAGES-2:0], dat_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sync_q <= clk_sync_d;
      dat_sync_q <= dat_sync_d;
      clk_prev_q <= clk_sync_q[STAGES-1];
    end
  end

  assign rise  = clk_sync_q[STAGES-1] & ~clk_prev_q;
  assign dat_s = dat_sync_q[STAGES-1];

  // R3: a detected edge never repeats in back-to-back cycles
  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/kbd_rx_shift.sv
`timescale 1ns/1ps
module kbd_rx_shift #(
  parameter int unsigned FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  input  logic               clr,
  output logic [FRAME_W-1:0] sr_q,
  output logic               top
);
  localparam int unsigned TOP = FRAME_W - 1;
  logic [FRAME_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clr)
      sr_d = '0;
    else if (shift_en && !sr_q[TOP])
      sr_d = {sr_q[TOP-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign top = sr_q[TOP];

  // R5: a held frame is frozen until cleared
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[TOP] && !clr) |=> $stable(sr_q));
  // R3: the sampled data bit enters stage 0 on an accepted edge
  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !sr_q[TOP] && !clr) |=> (sr_q[0] == $past(din)));
  // R6: clear empties the register
  p_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sr_q[TOP]);
endmodule

// File: rtl/kbd_rx_hold.sv
`timescale 1ns/1ps
module kbd_rx_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic top,
  input  logic clr,
  output logic done_q
);
  logic done_d;

  always_comb begin
    done_d = done_q;
    if (clr)      done_d = 1'b0;
    else if (top) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  // R5: sticky until cleared
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q);
  // R6: clear releases the flag
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done_q);
endmodule

// File: rtl/kbd_host_rx.sv
`timescale 1ns/1ps
module kbd_host_rx
  import kbd_rx_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_clk_rel,
  input  logic              kbd_dat_rel,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              kbd_clk_drive_low,
  output logic              kbd_dat_drive_low,
  output logic              irq,
  output logic [CODE_W-1:0] rd_data
);
  localparam int unsigned FRAME_W = CODE_W + 1;

  kbd_ctl_t           ctl_q, ctl_d;
  logic               clk_line, dat_line;
  logic               clk_rise, dat_s;
  logic [FRAME_W-1:0] frame_q;
  logic               frame_top;
  logic               held;
  logic [CODE_W-1:0]  code;
  logic               unused_wbits;

  assign unused_wbits = ^{ctl_wdata[CTL_CLKEN_BIT-1:0]};

  // control register
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.clr    = ctl_wdata[CTL_CLR_BIT];
      ctl_d.clk_en = ctl_wdata[CTL_CLKEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // open-drain line resolution
  assign kbd_clk_drive_low = ~ctl_q.clk_en;
  assign kbd_dat_drive_low = held;
  assign clk_line = kbd_clk_rel & ~kbd_clk_drive_low;
  assign dat_line = kbd_dat_rel & ~kbd_dat_drive_low;

  kbd_rx_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .clk_line(clk_line), .dat_line(dat_line),
    .rise(clk_rise), .dat_s(dat_s)
  );

  kbd_rx_shift #(.FRAME_W(FRAME_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .din(dat_s),
    .clr(ctl_q.clr), .sr_q(frame_q), .top(frame_top)
  );

  kbd_rx_hold hold_i (
    .clk(clk), .rst_n(rst_n), .top(frame_top), .clr(ctl_q.clr),
    .done_q(held)
  );

  // first code bit sits just below the start bit: reverse order
  for (genvar i = 0; i < CODE_W; i++) begin : g_code
    assign code[i] = frame_q[CODE_W-1-i];
  end

  assign irq     = held;
  assign rd_data = ctl_q.clr ? '0 : code;

  // R4: interrupt only while a complete frame is held
  p_irq_needs_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> frame_top);
  // R1: interrupt rises only after the start bit reached the top
  p_irq_after_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_top));
  // R7: clear set keeps the interrupt low on the next cycle
  p_clear_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.clr |=> !irq);
endmodule

// File: tb/kbd_host_rx_tb_top.sv
`timescale 1ns/1ps
module kbd_host_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk_rel = 1'b1;
  logic       kbd_dat_rel = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       kbd_clk_drive_low, kbd_dat_drive_low, irq;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  kbd_host_rx dut_i (
    .clk(clk), .rst_n(rst_n), .kbd_clk_rel(kbd_clk_rel), .kbd_dat_rel(kbd_dat_rel),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .kbd_clk_drive_low(kbd_clk_drive_low),
    .kbd_dat_drive_low(kbd_dat_drive_low), .irq(irq), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic kbd_bit(input logic b);
    @(negedge clk); kbd_dat_rel = b; kbd_clk_rel = 1'b0;
    repeat (4) @(negedge clk);
    kbd_clk_rel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // sends frame bits [0..nbits-1]: bit 0 is the start bit
  task automatic send(input logic [7:0] code, input int nbits);
    for (int k = 0; k < nbits; k++)
      kbd_bit(k == 0 ? 1'b1 : code[k-1]);
    repeat (6) @(negedge clk);
  endtask

  task automatic release_link();
    write_ctl(8'hC0);
    write_ctl(8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 rd_data", rd_data, 8'h00);
    chk("R9 clk held", {7'd0, kbd_clk_drive_low}, 8'h01);
    chk("R9 dat free", {7'd0, kbd_dat_drive_low}, 8'h00);

    // R8: clock owned by host, keyboard pulses ignored
    send(8'hFF, 9);
    chk("R8 clk held", {7'd0, kbd_clk_drive_low}, 8'h01);
    chk("R8 no frame", {7'd0, irq}, 8'h00);
    chk("R8 rd_data", rd_data, 8'h00);
    release_link();
    chk("R8 clk released", {7'd0, kbd_clk_drive_low}, 8'h00);

    // R1/R2/R4/R10: sweep every scancode
    for (int c = 0; c < 256; c++) begin
      send(8'(c), 9);
      chk("R1 irq set", {7'd0, irq}, 8'h01);
      chk("R4 clamp", {7'd0, kbd_dat_drive_low}, 8'h01);
      chk("R2 R10 code", rd_data, 8'(c));
      write_ctl(8'hC0);
      chk("R7 hidden", rd_data, 8'h00);
      chk("R6 irq clear", {7'd0, irq}, 8'h00);
      chk("R6 clamp off", {7'd0, kbd_dat_drive_low}, 8'h00);
      write_ctl(8'h40);
    end

    // R1: eight edges are not enough
    send(8'h5A, 8);
    chk("R1 partial", {7'd0, irq}, 8'h00);
    kbd_bit(1'b0);
    repeat (6) @(negedge clk);
    chk("R1 ninth edge", {7'd0, irq}, 8'h01);
    chk("R2 code 5A", rd_data, 8'h5A);

    // R5: held frame frozen against more traffic
    send(8'h3C, 9);
    chk("R5 irq sticky", {7'd0, irq}, 8'h01);
    chk("R5 clamp sticky", {7'd0, kbd_dat_drive_low}, 8'h01);
    chk("R5 frozen", rd_data, 8'h5A);
    release_link();

    // R6: all-ones after clear needs nine edges
    send(8'hFF, 8);
    chk("R6 window", {7'd0, irq}, 8'h00);
    kbd_bit(1'b1);
    repeat (6) @(negedge clk);
    chk("R6 complete", {7'd0, irq}, 8'h01);
    chk("R6 code FF", rd_data, 8'hFF);

    // R7: frame sent while clear is held
    write_ctl(8'hC0);
    send(8'h77, 9);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    chk("R7 rd zero", rd_data, 8'h00);
    write_ctl(8'h40);
    chk("R7 after release", {7'd0, irq}, 8'h00);
    send(8'h81, 9);
    chk("R7 next frame", rd_data, 8'h81);
    release_link();

    // R6/R7: clear colliding with frame completion
    for (int off = 0; off < 7; off++) begin
      send(8'h96, 8);
      @(negedge clk); kbd_dat_rel = 1'b1; kbd_clk_rel = 1'b0;
      repeat (4) @(negedge clk);
      kbd_clk_rel = 1'b1;
      repeat (off) @(negedge clk);
      write_ctl(8'hC0);
      chk("R6 collide irq", {7'd0, irq}, 8'h00);
      chk("R6 collide clamp", {7'd0, kbd_dat_drive_low}, 8'h00);
      chk("R7 collide rd", rd_data, 8'h00);
      write_ctl(8'h40);
      repeat (4) @(negedge clk);
      send(8'h69, 9);
      chk("R6 recover", rd_data, 8'h69);
      chk("R4 recover irq", {7'd0, irq}, 8'h01);
      release_link();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule